// File: doc/BRIEF.md
# Shared Mailbox Memory with Cross Doorbells

This block is a small shared memory that two bus masters use to exchange messages. An 8-bit host reaches it one byte at a time through a register window. A 32-bit core reaches it a word at a time through a Wishbone slave port with per-byte lane enables. Neither side is ever stalled: a host access completes at the next clock edge, and every core access is acknowledged in the cycle after it is presented.

The top of the memory holds two doorbells. One byte serves as the doorbell toward the host. The top word serves as the doorbell toward the core. A write from the opposite side raises an interrupt line toward the owner. The owner clears that line by reading its own doorbell. Doorbell bytes are also ordinary storage. Both sides may read and write them, and a write from the owning side changes only the stored value.

Byte offset `4*w + k` sits in core word `w`, lane `k` (bits `8k+7:8k`). Both ports return read data from a register one edge after the request. That data is the content before any write made in the same cycle.

Top module: `shmbx_top`

## Requirements
- R1: After reset both interrupt lines are low, the acknowledge is low, and every byte reads as zero from either port.
- R2: A byte the host writes at offset `a` reads back from the host at offset `a`, and from the core in word `a/4`, lane `a%4` (little-endian lanes).
- R3: A core write changes only the bytes whose lane enable is set. The other bytes of that word keep their value.
- R4: A core request (cycle and strobe high) is acknowledged by a one-cycle pulse on the next edge. Read data is valid while the acknowledge is high.
- R5: A core write whose lane enables include offset 0x3B (word 14, lane 3) raises the host interrupt at the next edge. A host write to 0x3B raises nothing.
- R6: A host read of offset 0x3B clears the host interrupt at the next edge.
- R7: A host write to offset 0x3F raises the core interrupt at the next edge. Host writes to 0x3C–0x3E and core writes to word 15 raise nothing.
- R8: A core read of word 15 (offsets 0x3C–0x3F) with any nonzero lane enable clears the core interrupt at the next edge.
- R9: Doorbell bytes hold the value most recently written by either side, and either side can read them.
- R10: When both sides write the same byte in the same cycle, the host's value is stored.
- R11: When a doorbell sees a raise and a clear in the same cycle, its interrupt is high after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access request for this cycle |
| host_we | input | 1 | Host access is a write |
| host_addr | input | DEPTH_LOG2 | Host byte offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| host_irq | output | 1 | Interrupt toward the host |
| wb_cyc_i | input | 1 | Wishbone cycle |
| wb_stb_i | input | 1 | Wishbone strobe |
| wb_we_i | input | 1 | Wishbone write enable |
| wb_adr_i | input | DEPTH_LOG2-2 | Wishbone word address |
| wb_sel_i | input | 4 | Wishbone byte lane enables |
| wb_dat_i | input | 32 | Wishbone write data |
| wb_dat_o | output | 32 | Wishbone read data |
| wb_ack_o | output | 1 | Wishbone acknowledge |
| core_irq | output | 1 | Interrupt toward the core |

## Verification
The bench builds the block with its default depth of 64 bytes. At that depth the doorbell offsets 0x3B and 0x3C–0x3F take their working values, so the bench exercises both doorbells, the shared word at 0x38 that mixes plain storage with the host doorbell, and partial lane enables on the top word. Same-cycle cases are driven on both ports together at this depth: a byte written by both sides, and a raise paired with a clear on each doorbell.

// File: rtl/shmbx_pkg.sv
package shmbx_pkg;

    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = 4;
    localparam int unsigned WORD_W = LANE_W * LANES;

    // Byte offset of the doorbell toward the host
    function automatic int unsigned host_bell_off(input int unsigned depth);
        return depth - 5;
    endfunction

    // First byte offset of the doorbell word toward the core
    function automatic int unsigned core_bell_base(input int unsigned depth);
        return depth - 4;
    endfunction

    // Byte whose host write rings the core
    function automatic int unsigned core_bell_trig(input int unsigned depth);
        return depth - 1;
    endfunction

    typedef struct packed {
        logic raise;
        logic clear;
    } bell_ev_t;

endpackage

// File: rtl/shmbx_store.sv
module shmbx_store
    import shmbx_pkg::*;
#(
    parameter int unsigned DEPTH_LOG2 = 6
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               h_we,
    input  logic [DEPTH_LOG2-1:0]              h_addr,
    input  logic [LANE_W-1:0]                  h_wdata,
    input  logic                               c_we,
    input  logic [DEPTH_LOG2-$clog2(LANES)-1:0] c_word,
    input  logic [LANES-1:0]                   c_sel,
    input  logic [WORD_W-1:0]                  c_wdata,
    output logic [(2**DEPTH_LOG2)*LANE_W-1:0]  mem_flat
);

    localparam int unsigned DEPTH   = 2 ** DEPTH_LOG2;
    localparam int unsigned WORD_AW = DEPTH_LOG2 - $clog2(LANES);

    for (genvar i = 0; i < DEPTH; i++) begin : g_byte
        localparam int unsigned LN = i % LANES;
        logic              h_hit;
        logic              c_hit;
        logic [LANE_W-1:0] byte_q;

        assign h_hit = h_we && (h_addr == DEPTH_LOG2'(i));
        assign c_hit = c_we && (c_word == WORD_AW'(i / LANES)) && c_sel[LN];

        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= '0;
            end else if (h_hit) begin
                byte_q <= h_wdata;
            end else if (c_hit) begin
                byte_q <= c_wdata[LANE_W*LN +: LANE_W];
            end
        end

        assign mem_flat[LANE_W*i +: LANE_W] = byte_q;

        AST_HOST_WINS: assert property (@(posedge clk) disable iff (rst)
            (h_hit && c_hit) |=> (byte_q == $past(h_wdata))); // R10
    end

endmodule

// File: rtl/shmbx_host_port.sv
module shmbx_host_port
    import shmbx_pkg::*;
#(
    parameter int unsigned DEPTH_LOG2 = 6
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              host_sel,
    input  logic                              host_we,
    input  logic [DEPTH_LOG2-1:0]             host_addr,
    input  logic [(2**DEPTH_LOG2)*LANE_W-1:0] mem_flat,
    output logic                              h_wr_en,
    output logic [LANE_W-1:0]                 host_rdata,
    output logic                              ring_core,
    output logic                              ack_host_bell
);

    localparam int unsigned DEPTH = 2 ** DEPTH_LOG2;
    localparam logic [DEPTH_LOG2-1:0] HBELL_A = DEPTH_LOG2'(host_bell_off(DEPTH));
    localparam logic [DEPTH_LOG2-1:0] CTRIG_A = DEPTH_LOG2'(core_bell_trig(DEPTH));

    logic h_rd_en;

    assign h_wr_en       = host_sel && host_we;
    assign h_rd_en       = host_sel && !host_we;
    assign ring_core     = h_wr_en && (host_addr == CTRIG_A);
    assign ack_host_bell = h_rd_en && (host_addr == HBELL_A);

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
        end else if (h_rd_en) begin
            host_rdata <= mem_flat[int'(host_addr)*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/shmbx_core_port.sv
module shmbx_core_port
    import shmbx_pkg::*;
#(
    parameter int unsigned DEPTH_LOG2 = 6
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wb_cyc,
    input  logic                                wb_stb,
    input  logic                                wb_we,
    input  logic [DEPTH_LOG2-$clog2(LANES)-1:0] wb_adr,
    input  logic [LANES-1:0]                    wb_sel,
    input  logic [(2**DEPTH_LOG2)*LANE_W-1:0]   mem_flat,
    output logic                                wb_ack,
    output logic [WORD_W-1:0]                   wb_rdat,
    output logic                                c_wr_en,
    output logic                                ring_host,
    output logic                                ack_core_bell
);

    localparam int unsigned DEPTH   = 2 ** DEPTH_LOG2;
    localparam int unsigned WORD_AW = DEPTH_LOG2 - $clog2(LANES);
    localparam int unsigned HB_OFF  = host_bell_off(DEPTH);
    localparam logic [WORD_AW-1:0] HB_WORD = WORD_AW'(HB_OFF / LANES);
    localparam int unsigned        HB_LANE = HB_OFF % LANES;
    localparam logic [WORD_AW-1:0] CB_WORD = WORD_AW'(core_bell_base(DEPTH) / LANES);

    logic req;
    logic c_rd_en;

    assign req           = wb_cyc && wb_stb && !wb_ack;
    assign c_wr_en       = req && wb_we;
    assign c_rd_en       = req && !wb_we;
    assign ring_host     = c_wr_en && (wb_adr == HB_WORD) && wb_sel[HB_LANE];
    assign ack_core_bell = c_rd_en && (wb_adr == CB_WORD) && (|wb_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_ack  <= 1'b0;
            wb_rdat <= '0;
        end else begin
            wb_ack <= req;
            if (c_rd_en) begin
                wb_rdat <= mem_flat[int'(wb_adr)*WORD_W +: WORD_W];
            end
        end
    end

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        wb_ack |=> !wb_ack); // R4
    AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (rst)
        wb_ack |-> $past(wb_cyc && wb_stb)); // R4

endmodule

// File: rtl/shmbx_bell.sv
module shmbx_bell
    import shmbx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bell_ev_t ev,
    output logic     irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else if (ev.raise) begin
            irq <= 1'b1;
        end else if (ev.clear) begin
            irq <= 1'b0;
        end
    end

    AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(ev.raise)); // R5, R7
    AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> ($past(ev.clear) && !$past(ev.raise))); // R6, R8
    AST_RAISE_WINS: assert property (@(posedge clk) disable iff (rst)
        ev.raise |=> irq); // R11
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (ev.clear && !ev.raise) |=> !irq); // R6, R8

endmodule

// File: rtl/shmbx_top.sv
module shmbx_top
    import shmbx_pkg::*;
#(
    parameter int unsigned DEPTH_LOG2 = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_sel,
    input  logic                  host_we,
    input  logic [DEPTH_LOG2-1:0] host_addr,
    input  logic [7:0]            host_wdata,
    output logic [7:0]            host_rdata,
    output logic                  host_irq,
    input  logic                  wb_cyc_i,
    input  logic                  wb_stb_i,
    input  logic                  wb_we_i,
    input  logic [DEPTH_LOG2-3:0] wb_adr_i,
    input  logic [3:0]            wb_sel_i,
    input  logic [31:0]           wb_dat_i,
    output logic [31:0]           wb_dat_o,
    output logic                  wb_ack_o,
    output logic                  core_irq
);

    localparam int unsigned DEPTH = 2 ** DEPTH_LOG2;

    logic [DEPTH*LANE_W-1:0] mem_flat;
    logic                    h_wr_en;
    logic                    c_wr_en;
    bell_ev_t                host_ev;
    bell_ev_t                core_ev;

    shmbx_host_port #(.DEPTH_LOG2(DEPTH_LOG2)) u_host (
        .clk           (clk),
        .rst           (rst),
        .host_sel      (host_sel),
        .host_we       (host_we),
        .host_addr     (host_addr),
        .mem_flat      (mem_flat),
        .h_wr_en       (h_wr_en),
        .host_rdata    (host_rdata),
        .ring_core     (core_ev.raise),
        .ack_host_bell (host_ev.clear)
    );

    shmbx_core_port #(.DEPTH_LOG2(DEPTH_LOG2)) u_core (
        .clk           (clk),
        .rst           (rst),
        .wb_cyc        (wb_cyc_i),
        .wb_stb        (wb_stb_i),
        .wb_we         (wb_we_i),
        .wb_adr        (wb_adr_i),
        .wb_sel        (wb_sel_i),
        .mem_flat      (mem_flat),
        .wb_ack        (wb_ack_o),
        .wb_rdat       (wb_dat_o),
        .c_wr_en       (c_wr_en),
        .ring_host     (host_ev.raise),
        .ack_core_bell (core_ev.clear)
    );

    shmbx_store #(.DEPTH_LOG2(DEPTH_LOG2)) u_store (
        .clk      (clk),
        .rst      (rst),
        .h_we     (h_wr_en),
        .h_addr   (host_addr),
        .h_wdata  (host_wdata),
        .c_we     (c_wr_en),
        .c_word   (wb_adr_i),
        .c_sel    (wb_sel_i),
        .c_wdata  (wb_dat_i),
        .mem_flat (mem_flat)
    );

    shmbx_bell u_bell_host (
        .clk (clk),
        .rst (rst),
        .ev  (host_ev),
        .irq (host_irq)
    );

    shmbx_bell u_bell_core (
        .clk (clk),
        .rst (rst),
        .ev  (core_ev),
        .irq (core_irq)
    );

endmodule

// File: tb/shmbx_top_tb_top.sv
`timescale 1ns/1ps
module shmbx_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_sel, host_we;
    logic [5:0]  host_addr;
    logic [7:0]  host_wdata, host_rdata;
    logic        host_irq, core_irq;
    logic        wb_cyc_i, wb_stb_i, wb_we_i;
    logic [3:0]  wb_adr_i, wb_sel_i;
    logic [31:0] wb_dat_i, wb_dat_o;
    logic        wb_ack_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    shmbx_top dut_i (
        .clk(clk), .rst(rst),
        .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
        .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
        .wb_adr_i(wb_adr_i), .wb_sel_i(wb_sel_i), .wb_dat_i(wb_dat_i),
        .wb_dat_o(wb_dat_o), .wb_ack_o(wb_ack_o), .core_irq(core_irq)
    );

    // op: 0 host write, 1 host read, 2 core write, 3 core read
    // fields: op(2) addr(6) sel(4) data(32) exp(32)
    localparam int NV = 14;
    localparam logic [75:0] VEC [NV] = '{
        {2'd0, 6'h00, 4'h0, 32'h000000A5, 32'h0},          // R2
        {2'd1, 6'h00, 4'h0, 32'h0,        32'h000000A5},   // R2
        {2'd3, 6'h00, 4'hF, 32'h0,        32'h000000A5},   // R2
        {2'd2, 6'h04, 4'hF, 32'h11223344, 32'h0},          // R3
        {2'd1, 6'h04, 4'h0, 32'h0,        32'h00000044},   // R2
        {2'd1, 6'h07, 4'h0, 32'h0,        32'h00000011},   // R2
        {2'd2, 6'h04, 4'h5, 32'hAABBCCDD, 32'h0},          // R3
        {2'd3, 6'h04, 4'hF, 32'h0,        32'h11BB33DD},   // R3
        {2'd0, 6'h3A, 4'h0, 32'h0000007E, 32'h0},          // R2
        {2'd3, 6'h38, 4'hF, 32'h0,        32'h007E0000},   // R2
        {2'd0, 6'h3B, 4'h0, 32'h0000005C, 32'h0},          // R5 own-bell write
        {2'd3, 6'h38, 4'hF, 32'h0,        32'h5C7E0000},   // R9
        {2'd0, 6'h3D, 4'h0, 32'h0000009B, 32'h0},          // R7 non-trigger byte
        {2'd3, 6'h3C, 4'hF, 32'h0,        32'h00009B00}    // R9
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        host_sel = 0; host_we = 0; host_addr = '0; host_wdata = '0;
        wb_cyc_i = 0; wb_stb_i = 0; wb_we_i = 0; wb_adr_i = '0; wb_sel_i = '0; wb_dat_i = '0;
    endtask

    // One cycle on both ports at once; outputs sampled at the following negedge
    task automatic drive(input logic hs, input logic hw, input logic [5:0] ha, input logic [7:0] hd,
                         input logic cs, input logic cw, input logic [5:0] ca,
                         input logic [3:0] csel, input logic [31:0] cd);
        @(negedge clk);
        host_sel = hs; host_we = hw; host_addr = ha; host_wdata = hd;
        wb_cyc_i = cs; wb_stb_i = cs; wb_we_i = cw; wb_adr_i = ca[5:2]; wb_sel_i = csel; wb_dat_i = cd;
        @(negedge clk);
        idle();
    endtask

    task automatic hwr(input logic [5:0] a, input logic [7:0] d);
        drive(1, 1, a, d, 0, 0, 6'h0, 4'h0, 32'h0);
    endtask

    task automatic hrd(input logic [5:0] a, input logic [7:0] exp, input string tag);
        drive(1, 0, a, 8'h0, 0, 0, 6'h0, 4'h0, 32'h0);
        chk(tag, {24'h0, host_rdata}, {24'h0, exp});
    endtask

    task automatic cwr(input logic [5:0] a, input logic [3:0] s, input logic [31:0] d);
        drive(0, 0, 6'h0, 8'h0, 1, 1, a, s, d);
        chk("R4 ack on write", {31'h0, wb_ack_o}, 32'h1);
    endtask

    task automatic crd(input logic [5:0] a, input logic [3:0] s, input logic [31:0] exp, input string tag);
        drive(0, 0, 6'h0, 8'h0, 1, 0, a, s, 32'h0);
        chk("R4 ack on read", {31'h0, wb_ack_o}, 32'h1);
        chk(tag, wb_dat_o, exp);
    endtask

    task automatic irqs(input logic hexp, input logic cexp, input string tag);
        chk({tag, " host_irq"}, {31'h0, host_irq}, {31'h0, hexp});
        chk({tag, " core_irq"}, {31'h0, core_irq}, {31'h0, cexp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        irqs(0, 0, "R1");
        chk("R1 ack", {31'h0, wb_ack_o}, 32'h0);
        hrd(6'h20, 8'h00, "R1 host byte");
        crd(6'h30, 4'hF, 32'h0, "R1 core word");
        @(negedge clk);
        chk("R4 ack single pulse", {31'h0, wb_ack_o}, 32'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [5:0]  a;
            logic [3:0]  s;
            logic [31:0] d, e;
            {op, a, s, d, e} = VEC[i];
            case (op)
                2'd0: hwr(a, d[7:0]);
                2'd1: hrd(a, e[7:0], "R2 host read");
                2'd2: cwr(a, s, d);
                default: crd(a, s, e, "R2/R3/R9 core read");
            endcase
            irqs(0, 0, "R5/R7 no self ring");
        end

        // R5 core rings the host
        cwr(6'h38, 4'h8, 32'h12000000);
        irqs(1, 0, "R5");
        // R6 host read of its bell clears; R9 byte kept
        hrd(6'h3B, 8'h12, "R9 host bell value");
        irqs(0, 0, "R6");

        // R7 host rings the core
        hwr(6'h3F, 8'h77);
        irqs(0, 1, "R7");
        // R8 partial-lane read of top word clears
        crd(6'h3C, 4'h2, 32'h77009B00, "R9 core bell value");
        irqs(0, 0, "R8");
        // R7 core writing its own bell only stores
        cwr(6'h3C, 4'h8, 32'h66000000);
        irqs(0, 0, "R7 core self write");
        hrd(6'h3F, 8'h66, "R9 core bell written by core");

        // R11 host bell: raise and clear together
        cwr(6'h38, 4'h8, 32'h21000000);
        irqs(1, 0, "R5 re-ring");
        drive(1, 0, 6'h3B, 8'h0, 1, 1, 6'h38, 4'h8, 32'h34000000);
        irqs(1, 0, "R11 host bell");
        hrd(6'h3B, 8'h34, "R9 host bell after collision");
        irqs(0, 0, "R6 after R11");

        // R11 core bell: raise and clear together
        hwr(6'h3F, 8'h01);
        irqs(0, 1, "R7 re-ring");
        drive(1, 1, 6'h3F, 8'h02, 1, 0, 6'h3C, 4'hF, 32'h0);
        irqs(0, 1, "R11 core bell");
        crd(6'h3C, 4'hF, 32'h02009B00, "R9 core bell after collision");
        irqs(0, 0, "R8 after R11");

        // R10 same-byte collision, host wins; neighbour lane takes core data
        drive(1, 1, 6'h10, 8'hAA, 1, 1, 6'h10, 4'h3, 32'h00005555);
        hrd(6'h10, 8'hAA, "R10 host wins");
        hrd(6'h11, 8'h55, "R3 other lane from core");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule